// File: doc/BRIEF.md
# Safety Error Interrupt Aggregator

This block collects seven single-cycle error event pulses from safety logic elsewhere in the chip and latches them into interrupt status bits. Software reaches the bits over a small 32-bit register bus with a word address. It can read the status directly, or read it through a mask view. It can write the per-source enable mask, clear bits by writing ones, and inject events through a write-only trigger register to test the interrupt path.

Two level outputs are built from the latched bits. The correctable SRAM error drives the non-fatal line. Every other source drives the fatal line. A source whose mask bit is set is never latched, whether its event comes from hardware or from the trigger register. A clearing write through either status view acts on the single set of stored bits, so both views always agree.

Top module: `safety_err_aggregator`

## Requirements
- R1: After reset, the status bits and the mask are all 0. Both interrupt outputs are low, and the read data is 0.
- R2: A pulse on `err_evt_i[i]` sets status bit i when mask bit i is 0. The bit is then visible one cycle after the pulse. The bit order from 0 to 6 is: SRAM correctable, SRAM uncorrectable, address/data path parity, control-register, transaction timeout, protocol, integrity.
- R3: While mask bit i is 1, an event on source i leaves status bit i unchanged.
- R4: A write to the raw status view (word address 0) clears every bit written as 1. Bits written as 0 keep their value.
- R5: A write to the masked status view (word address 1) clears the same bits as R4. Both views then read those bits as 0.
- R6: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Writing ones to the trigger register (word address 3) sets the matching status bits as though hardware events had arrived, subject to the mask. The trigger register reads as 0.
- R8: `irq_nonfatal_o` is high exactly when status bit 0 is set. `irq_fatal_o` is high exactly when any of status bits 1 to 6 is set.
- R9: Read data bits 31:7 are always 0 for every address. Writes to those bit positions have no effect. The mask register (word address 2) holds only bits 6:0.
- R10: The masked view returns the raw status AND NOT the mask. The raw view and the outputs keep a bit that was latched before its mask bit was set.
- R11: A read returns data on `bus_rdata_o` in the cycle after `bus_rd_i`. A read has no side effect on any stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_evt_i | input | 7 | Error event pulses, one per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_fatal_o | output | 1 | Fatal interrupt level |
| irq_nonfatal_o | output | 1 | Non-fatal interrupt level |

## Verification
The main function is tried with four kinds of stimulus: single events on the sources at each end of the bit range, several events in one cycle, events on masked sources, and events injected through the trigger register. Together these separate the mask gating from the latching and show each bit in its own position. Clearing writes are aimed at both status views and sometimes collide with a new event, which shows that storage is shared and that a set has priority. Reads of the masked view, the trigger register and the reserved bits show what each view returns, as distinct from what is stored.

// File: rtl/sea_pkg.sv
package sea_pkg;
    localparam int unsigned SRC_N  = 7;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;

    // word addresses of the register views
    localparam int unsigned WA_RAW   = 0;
    localparam int unsigned WA_MVIEW = 1;
    localparam int unsigned WA_MASK  = 2;
    localparam int unsigned WA_TRIG  = 3;

    // bit 0 (correctable SRAM) is the only non-fatal source
    localparam logic [SRC_N-1:0] NONFATAL_SEL = 7'b000_0001;
endpackage

// File: rtl/sea_regbus.sv
module sea_regbus #(
    parameter int unsigned N      = sea_pkg::SRC_N,
    parameter int unsigned DATA_W = sea_pkg::DATA_W,
    parameter int unsigned ADDR_W = sea_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      status_i,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      clr_o,
    output logic [N-1:0]      inj_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(sea_pkg::WA_RAW);
    localparam logic [ADDR_W-1:0] A_MVIEW = ADDR_W'(sea_pkg::WA_MVIEW);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(sea_pkg::WA_MASK);
    localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(sea_pkg::WA_TRIG);

    typedef struct packed {
        logic [N-1:0]      mask;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t st_d, st_q;
    logic [N-1:0] wbits;
    logic         unused_whi;

    assign wbits      = wdata_i[N-1:0];
    assign unused_whi = ^wdata_i[DATA_W-1:N];

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        inj_o = '0;
        if (wr_i) begin
            case (addr_i)
                A_RAW, A_MVIEW: clr_o     = wbits;
                A_MASK:         st_d.mask = wbits;
                A_TRIG:         inj_o     = wbits;
                default: ;
            endcase
        end
        if (rd_i) begin
            st_d.rdata = '0;
            case (addr_i)
                A_RAW:   st_d.rdata[N-1:0] = status_i;
                A_MVIEW: st_d.rdata[N-1:0] = status_i & ~st_q.mask;
                A_MASK:  st_d.rdata[N-1:0] = st_q.mask;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o  = st_q.mask;
    assign rdata_o = st_q.rdata;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:N] == '0); // R9
endmodule

// File: rtl/sea_status.sv
module sea_status #(
    parameter int unsigned N = sea_pkg::SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] inj_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    typedef struct packed {
        logic [N-1:0] status;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [N-1:0] set_w;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign set_w[i] = (evt_i[i] | inj_i[i]) & ~mask_i[i];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a set in the same cycle beats a clear
            st_d.status[i] = set_w[i] | (st_q.status[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past((evt_i | inj_i) & ~mask_i)) ==
                  $past((evt_i | inj_i) & ~mask_i))); // R2
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & $past(mask_i)) == '0)); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(clr_i & ~(evt_i | inj_i))) == '0)); // R4
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(clr_i & evt_i & ~mask_i)) ==
                  $past(clr_i & evt_i & ~mask_i))); // R6
endmodule

// File: rtl/sea_irq.sv
module sea_irq #(
    parameter int unsigned  N      = sea_pkg::SRC_N,
    parameter logic [N-1:0] NF_SEL = sea_pkg::NONFATAL_SEL
) (
    input  logic [N-1:0] status_i,
    output logic         fatal_o,
    output logic         nonfatal_o
);
    logic [N-1:0] fat_bits, nf_bits;

    for (genvar i = 0; i < N; i++) begin : g_route
        if (NF_SEL[i]) begin : g_nf
            assign nf_bits[i]  = status_i[i];
            assign fat_bits[i] = 1'b0;
        end else begin : g_fat
            assign nf_bits[i]  = 1'b0;
            assign fat_bits[i] = status_i[i];
        end
    end

    assign fatal_o    = |fat_bits;
    assign nonfatal_o = |nf_bits;
endmodule

// File: rtl/safety_err_aggregator.sv
module safety_err_aggregator #(
    parameter int unsigned N      = sea_pkg::SRC_N,
    parameter int unsigned DATA_W = sea_pkg::DATA_W,
    parameter int unsigned ADDR_W = sea_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      err_evt_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_fatal_o,
    output logic              irq_nonfatal_o
);
    logic [N-1:0] status, mask, clr, inj;

    sea_regbus #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regbus (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (status),
        .mask_o   (mask),
        .clr_o    (clr),
        .inj_o    (inj),
        .rdata_o  (bus_rdata_o)
    );

    sea_status #(.N(N)) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (err_evt_i),
        .inj_i    (inj),
        .mask_i   (mask),
        .clr_i    (clr),
        .status_o (status)
    );

    sea_irq #(.N(N)) i_irq (
        .status_i   (status),
        .fatal_o    (irq_fatal_o),
        .nonfatal_o (irq_nonfatal_o)
    );

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (!irq_fatal_o && !irq_nonfatal_o)); // R8
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fatal_o || irq_nonfatal_o) |-> (status != '0)); // R8
    AST_MASK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> ((status & $past(status)) == $past(status))); // R10
endmodule

// File: tb/test_safety_err_aggregator.sv
module test_safety_err_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  err_evt = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fatal, nonfatal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    safety_err_aggregator i_safety_err_aggregator (
        .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_fatal_o(fatal), .irq_nonfatal_o(nonfatal)
    );

    // {req[3:0], evt[6:0], wr, addr[3:0], wdata[6:0], exp_raw[6:0], exp_fatal, exp_nf}
    localparam logic [31:0] VEC [12] = '{
        {4'd2, 7'h01, 1'b0, 4'd0, 7'h00, 7'h01, 1'b0, 1'b1}, // R2 lowest source
        {4'd2, 7'h40, 1'b0, 4'd0, 7'h00, 7'h41, 1'b1, 1'b1}, // R2 highest source
        {4'd4, 7'h00, 1'b1, 4'd0, 7'h00, 7'h41, 1'b1, 1'b1}, // R4 zeros keep
        {4'd4, 7'h00, 1'b1, 4'd0, 7'h01, 7'h40, 1'b1, 1'b0}, // R4 clear bit 0
        {4'd5, 7'h00, 1'b1, 4'd1, 7'h40, 7'h00, 1'b0, 1'b0}, // R5 clear via masked view
        {4'd3, 7'h00, 1'b1, 4'd2, 7'h06, 7'h00, 1'b0, 1'b0}, // R3 mask bits 1,2
        {4'd3, 7'h0E, 1'b0, 4'd0, 7'h00, 7'h08, 1'b1, 1'b0}, // R3 masked events dropped
        {4'd7, 7'h00, 1'b1, 4'd3, 7'h03, 7'h09, 1'b1, 1'b1}, // R7 inject obeys mask
        {4'd6, 7'h01, 1'b1, 4'd0, 7'h09, 7'h01, 1'b0, 1'b1}, // R6 event beats clear
        {4'd8, 7'h00, 1'b1, 4'd2, 7'h00, 7'h01, 1'b0, 1'b1}, // R8 unmask all
        {4'd8, 7'h24, 1'b0, 4'd0, 7'h00, 7'h25, 1'b1, 1'b1}, // R8 multi-source
        {4'd5, 7'h00, 1'b1, 4'd1, 7'h7F, 7'h00, 1'b0, 1'b0}  // R5 clear all
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [6:0] e, input logic w, input logic [3:0] a,
                       input logic [31:0] d);
        @(negedge clk);
        err_evt = e; wr = w; addr = a; wdata = d;
        @(negedge clk);
        err_evt = '0; wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        check(rdata == 0 && !fatal && !nonfatal, "R1 outputs", {rdata[29:0], fatal, nonfatal}, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd_reg(4'(a), v);
            check(v == 0, "R1 reset read", v, 0);
        end

        foreach (VEC[k]) begin
            logic [31:0] t;
            t = VEC[k];
            cyc(t[27:21], t[20], t[19:16], {25'd0, t[15:9]});
            check({fatal, nonfatal} == t[1:0], $sformatf("R%0d irq vec %0d", t[31:28], k),
                  {30'd0, fatal, nonfatal}, {30'd0, t[1:0]});
            rd_reg(4'd0, v);
            check(v == {25'd0, t[8:2]}, $sformatf("R%0d raw vec %0d", t[31:28], k),
                  v, {25'd0, t[8:2]});
        end

        // R9: mask holds only 7 bits, reserved read 0
        cyc('0, 1'b1, 4'd2, 32'hFFFF_FFFF);
        rd_reg(4'd2, v);
        check(v == 32'h7F, "R9 mask width", v, 32'h7F);
        cyc('0, 1'b1, 4'd2, 32'h0000_0000);
        // R7: trigger reads 0 even after writing
        cyc('0, 1'b1, 4'd3, 32'hFFFF_FF80);
        rd_reg(4'd3, v);
        check(v == 0, "R7 trigger reads 0", v, 0);
        rd_reg(4'd0, v);
        check(v == 0, "R9 reserved trigger bits ignored", v, 0);

        // R10: mask after latch hides only the masked view
        cyc(7'h10, 1'b0, 4'd0, 0);
        cyc('0, 1'b1, 4'd2, 32'h10);
        rd_reg(4'd1, v);
        check(v == 0, "R10 masked view", v, 0);
        rd_reg(4'd0, v);
        check(v == 32'h10, "R10 raw keeps", v, 32'h10);
        check(fatal == 1'b1, "R10 fatal stays", {31'd0, fatal}, 1);

        // R11: repeated reads, no side effects
        rd_reg(4'd0, v);
        rd_reg(4'd0, v2);
        check(v == v2 && v == 32'h10, "R11 read no side effect", v2, 32'h10);

        // R1: reset mid-run clears all
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(!fatal && !nonfatal && rdata == 0, "R1 reset again", {30'd0, fatal, nonfatal}, 0);
        rst_n = 1'b1;
        rd_reg(4'd2, v);
        check(v == 0, "R1 mask reset", v, 0);

        done = 1'b1;
        summary();
    end
endmodule